// File: doc/BRIEF.md
# Serial Command Decoder for Board Glue Logic

This block is the serial slave side of a small glue-logic device. A host drives it over a four-wire serial bus in clock mode 0 (clock idles low, data sampled on the rising edge, changed on the falling edge), with an extra host-to-device line used only while NAND write data is streamed. The first byte of every chip-select-low frame is an opcode. The opcode decides how the following bytes are framed. A frame can replace an 8-bit configuration register, switch a separate indicator LED, stream bytes out to a NAND-side sink, or stream bytes from a NAND-side source back to the host on MISO after a number of dummy bytes.

All serial pins are sampled by the block's own clock through one register stage, and edges are found in that domain. The serial clock must therefore run well below the system clock: each serial clock level must last at least three system clocks. NAND data leaves and enters through valid/ready streams.

On the outbound write stream, a byte stays on `wr_data` with `wr_valid` high until the sink takes it. The sink must take each byte within one serial byte time (four serial clocks). Taking it in the same cycle that the next byte arrives is allowed. On the inbound read stream, the block raises `rd_ready` only when its single prefetch slot is empty during a read frame.

Top module: `spi_glue_cmd_decoder`

## Requirements
- R1: After reset the configuration register is 0x1F. `led_n` is 4'hF, `nand_ce_n` is 1, `spare_out` is 0 and `led5_n` is 1. `wr_valid`, `rd_ready` and `spi_miso` are 0.
- R2: Opcode 0x09 makes the next byte replace the configuration register. Bits 3:0 drive `led_n[3:0]`, bit 4 drives `nand_ce_n`, and bits 7:5 drive `spare_out[2:0]`. Any further bytes in that frame have no effect.
- R3: Opcode 0x0C drives `led5_n` to 0 and opcode 0x0D drives it to 1, both once the opcode byte is complete. Later bytes in the same frame have no effect.
- R4: After opcode 0x08, every serial clock delivers two bits, MOSI carrying the higher bit of each pair and the second line the lower, most significant pair first. Every byte except the last one of the frame is forwarded on the write stream in arrival order. The last byte is a trailer and is dropped.
- R5: While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and `wr_data` stays stable, unless the next byte arrives. A byte accepted in the same cycle that the next byte arrives is delivered, and the new byte follows it.
- R6: Opcode 0x0A is followed by one dummy byte. After it, each byte is shifted out on `spi_miso`, most significant bit first, each bit valid from a falling edge to the next rising edge.
- R7: Opcode 0x0B is followed by four dummy bytes before read data is shifted out the same way.
- R8: `rd_ready` is high only within a read frame while the prefetch slot is empty. A data byte with no byte in the slot is sent as 0xFF. A slot still holding a byte at the end of the frame is discarded.
- R9: Raising `spi_cs_n` at any point ends the frame. A partly received byte is discarded and the next frame starts with an opcode.
- R10: An opcode other than 0x08, 0x09, 0x0A, 0x0B, 0x0C or 0x0D, and every byte after it in the frame, changes no output.
- R11: `spi_miso` is 0 whenever no read data byte is being shifted out, including during opcode and dummy bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Host data; higher bit of a pair in dual mode |
| spi_mosi2 | input | 1 | Lower bit of a pair in dual mode |
| spi_miso | output | 1 | Device data to host |
| wr_valid | output | 1 | Write byte available |
| wr_ready | input | 1 | Sink accepts write byte |
| wr_data | output | 8 | Write byte to NAND side |
| rd_valid | input | 1 | Read byte offered by NAND side |
| rd_ready | output | 1 | Prefetch slot can take a byte |
| rd_data | input | 8 | Read byte from NAND side |
| led_n | output | 4 | Active-low LED drives |
| nand_ce_n | output | 1 | Active-low NAND chip enable |
| spare_out | output | 3 | Spare configuration outputs |
| led5_n | output | 1 | Active-low indicator LED |

## Verification
The write stream can be accepted by the sink in the same system cycle that a newly completed dual-mode byte pushes the next value into the output register. The bench holds `wr_ready` low after the first forwarded byte appears and releases it exactly one byte time later. That release lands the acceptance on the cycle of the second push. The bench judges the result by the bytes collected at the sink: all three payload bytes must arrive, in order, with no loss or duplicate, and the trailer must be absent.

// File: rtl/cpld_spi_pkg.sv
`timescale 1ns/1ps
package cpld_spi_pkg;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_CFG,
    ST_WR,
    ST_RD_DUMMY,
    ST_RD_DATA,
    ST_IGNORE
  } seq_state_e;

  localparam logic [7:0] OP_NAND_WR      = 8'h08;
  localparam logic [7:0] OP_CFG_WR       = 8'h09;
  localparam logic [7:0] OP_NAND_RD      = 8'h0A;
  localparam logic [7:0] OP_NAND_RD_FAST = 8'h0B;
  localparam logic [7:0] OP_LED5_ON      = 8'h0C;
  localparam logic [7:0] OP_LED5_OFF     = 8'h0D;

endpackage

// File: rtl/cpld_spi_rx.sv
`timescale 1ns/1ps
module cpld_spi_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic              mosi2,
  input  logic              dual,
  output logic              frame_on,
  output logic              sclk_fall,
  output logic              byte_start,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_q
);
  localparam int CNT_W = $clog2(DATA_W) + 1;

  logic s_sclk, s_cs_n, s_mosi, s_mosi2, p_sclk;
  logic sclk_rise;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [DATA_W-1:0] sh_q, sh_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sclk  <= 1'b0;
      s_cs_n  <= 1'b1;
      s_mosi  <= 1'b0;
      s_mosi2 <= 1'b0;
      p_sclk  <= 1'b0;
    end else begin
      s_sclk  <= sclk;
      s_cs_n  <= cs_n;
      s_mosi  <= mosi;
      s_mosi2 <= mosi2;
      p_sclk  <= s_sclk;
    end
  end

  assign frame_on   = ~s_cs_n;
  assign sclk_rise  = s_sclk & ~p_sclk & ~s_cs_n;
  assign sclk_fall  = ~s_sclk & p_sclk & ~s_cs_n;
  assign byte_start = (cnt_q == '0);

  always_comb begin
    if (dual) begin
      sh_nx  = {sh_q[DATA_W-3:0], s_mosi, s_mosi2};
      cnt_nx = cnt_q + CNT_W'(2);
    end else begin
      sh_nx  = {sh_q[DATA_W-2:0], s_mosi};
      cnt_nx = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      byte_done <= 1'b0;
      byte_q    <= '0;
    end else begin
      byte_done <= 1'b0;
      if (s_cs_n) begin
        cnt_q <= '0;
        sh_q  <= '0;
      end else if (sclk_rise) begin
        sh_q <= sh_nx;
        if (cnt_nx == CNT_W'(DATA_W)) begin
          cnt_q     <= '0;
          byte_done <= 1'b1;
          byte_q    <= sh_nx;
        end else begin
          cnt_q <= cnt_nx;
        end
      end
    end
  end
endmodule

// File: rtl/cpld_spi_seq.sv
`timescale 1ns/1ps
module cpld_spi_seq
  import cpld_spi_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LED_BITS   = 4,
  parameter int SLOW_DUMMY = 1,
  parameter int FAST_DUMMY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_on,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_q,
  output seq_state_e        state_o,
  output logic              dual_o,
  output logic              rd_phase_o,
  output logic              tx_load_o,
  output logic              wr_push_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic              led5_n_o
);
  localparam int DUMMY_MAX = (FAST_DUMMY > SLOW_DUMMY) ? FAST_DUMMY : SLOW_DUMMY;
  localparam int DUMMY_W   = $clog2(DUMMY_MAX + 1);
  localparam int SPARE_W   = DATA_W - LED_BITS - 1;
  localparam logic [DATA_W-1:0] CFG_INIT = {{SPARE_W{1'b0}}, {(LED_BITS + 1){1'b1}}};

  seq_state_e         state_q;
  logic [DUMMY_W-1:0] dcnt_q;
  logic               last_dummy;

  assign last_dummy = (dcnt_q == DUMMY_W'(1));
  assign state_o    = state_q;
  assign dual_o     = (state_q == ST_WR);
  assign rd_phase_o = (state_q == ST_RD_DUMMY) || (state_q == ST_RD_DATA);
  assign tx_load_o  = byte_done &&
                      (((state_q == ST_RD_DUMMY) && last_dummy) || (state_q == ST_RD_DATA));
  assign wr_push_o  = byte_done && (state_q == ST_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_CMD;
      dcnt_q   <= '0;
      cfg_o    <= CFG_INIT;
      led5_n_o <= 1'b1;
    end else if (!frame_on) begin
      state_q <= ST_CMD;
      dcnt_q  <= '0;
    end else if (byte_done) begin
      case (state_q)
        ST_CMD: begin
          case (byte_q)
            DATA_W'(OP_CFG_WR):  state_q <= ST_CFG;
            DATA_W'(OP_NAND_WR): state_q <= ST_WR;
            DATA_W'(OP_NAND_RD): begin
              state_q <= ST_RD_DUMMY;
              dcnt_q  <= DUMMY_W'(SLOW_DUMMY);
            end
            DATA_W'(OP_NAND_RD_FAST): begin
              state_q <= ST_RD_DUMMY;
              dcnt_q  <= DUMMY_W'(FAST_DUMMY);
            end
            DATA_W'(OP_LED5_ON): begin
              led5_n_o <= 1'b0;
              state_q  <= ST_IGNORE;
            end
            DATA_W'(OP_LED5_OFF): begin
              led5_n_o <= 1'b1;
              state_q  <= ST_IGNORE;
            end
            default: state_q <= ST_IGNORE;
          endcase
        end
        ST_CFG: begin
          cfg_o   <= byte_q;
          state_q <= ST_IGNORE;
        end
        ST_RD_DUMMY: begin
          if (last_dummy) state_q <= ST_RD_DATA;
          else            dcnt_q  <= dcnt_q - DUMMY_W'(1);
        end
        default: state_q <= state_q;
      endcase
    end
  end
endmodule

// File: rtl/cpld_spi_tx.sv
`timescale 1ns/1ps
module cpld_spi_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_on,
  input  logic              rd_phase,
  input  logic              load,
  input  logic              sclk_fall,
  input  logic              byte_start,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso
);
  logic [DATA_W-1:0] slot_q, sh_q;
  logic              slot_v;
  logic              take;

  assign rd_ready = frame_on && rd_phase && !slot_v;
  assign take     = rd_valid && rd_ready;
  assign miso     = sh_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      slot_v <= 1'b0;
      sh_q   <= '0;
    end else if (!frame_on) begin
      slot_v <= 1'b0;
      sh_q   <= '0;
    end else begin
      if (load) begin
        sh_q   <= slot_v ? slot_q : '1;
        slot_v <= 1'b0;
      end else if (sclk_fall && !byte_start) begin
        sh_q <= {sh_q[DATA_W-2:0], 1'b0};
      end
      if (take) begin
        slot_q <= rd_data;
        slot_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpld_spi_wrbuf.sv
`timescale 1ns/1ps
module cpld_spi_wrbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_on,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] held_q;
  logic              held_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= '0;
      held_v   <= 1'b0;
      wr_data  <= '0;
      wr_valid <= 1'b0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (push) begin
        if (held_v) begin
          wr_data  <= held_q;
          wr_valid <= 1'b1;
        end
        held_q <= push_data;
        held_v <= 1'b1;
      end
      if (!frame_on) held_v <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_glue_cmd_decoder.sv
`timescale 1ns/1ps
module spi_glue_cmd_decoder
  import cpld_spi_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LED_BITS   = 4,
  parameter int SLOW_DUMMY = 1,
  parameter int FAST_DUMMY = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         spi_sclk,
  input  logic                         spi_cs_n,
  input  logic                         spi_mosi,
  input  logic                         spi_mosi2,
  output logic                         spi_miso,
  output logic                         wr_valid,
  input  logic                         wr_ready,
  output logic [DATA_W-1:0]            wr_data,
  input  logic                         rd_valid,
  output logic                         rd_ready,
  input  logic [DATA_W-1:0]            rd_data,
  output logic [LED_BITS-1:0]          led_n,
  output logic                         nand_ce_n,
  output logic [DATA_W-LED_BITS-2:0]   spare_out,
  output logic                         led5_n
);
  logic              frame_on, sclk_fall, byte_start, byte_done;
  logic [DATA_W-1:0] byte_q, cfg;
  logic              dual, rd_phase, tx_load, wr_push;
  seq_state_e        st;

  cpld_spi_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .mosi2(spi_mosi2), .dual(dual),
    .frame_on(frame_on), .sclk_fall(sclk_fall), .byte_start(byte_start),
    .byte_done(byte_done), .byte_q(byte_q)
  );

  cpld_spi_seq #(
    .DATA_W(DATA_W), .LED_BITS(LED_BITS),
    .SLOW_DUMMY(SLOW_DUMMY), .FAST_DUMMY(FAST_DUMMY)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_on(frame_on), .byte_done(byte_done),
    .byte_q(byte_q), .state_o(st), .dual_o(dual), .rd_phase_o(rd_phase),
    .tx_load_o(tx_load), .wr_push_o(wr_push), .cfg_o(cfg), .led5_n_o(led5_n)
  );

  cpld_spi_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_on(frame_on), .rd_phase(rd_phase),
    .load(tx_load), .sclk_fall(sclk_fall), .byte_start(byte_start),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .miso(spi_miso)
  );

  cpld_spi_wrbuf #(.DATA_W(DATA_W)) u_wrbuf (
    .clk(clk), .rst_n(rst_n), .frame_on(frame_on), .push(wr_push),
    .push_data(byte_q), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data)
  );

  assign led_n     = cfg[LED_BITS-1:0];
  assign nand_ce_n = cfg[LED_BITS];
  assign spare_out = cfg[DATA_W-1:LED_BITS+1];
endmodule

// File: rtl/spi_glue_cmd_decoder_chk.sv
`timescale 1ns/1ps
module spi_glue_cmd_decoder_chk
  import cpld_spi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_on,
  input logic              byte_done,
  input logic              wr_push,
  input seq_state_e        st,
  input logic [DATA_W-1:0] cfg,
  input logic              led5_n,
  input logic              spi_miso,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_ready
);
  p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid);

  p_wr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !wr_push) |=> $stable(wr_data));

  p_rd_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> (frame_on && (st == ST_RD_DUMMY || st == ST_RD_DATA)));

  p_miso_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_RD_DATA) |-> !spi_miso);

  p_cs_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_on |=> (st == ST_CMD));

  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> $past(st == ST_CFG && byte_done && frame_on));

  p_led5_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led5_n) |-> $past(st == ST_CMD && byte_done && frame_on));
endmodule

bind spi_glue_cmd_decoder spi_glue_cmd_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_on(frame_on), .byte_done(byte_done),
  .wr_push(wr_push), .st(st), .cfg(cfg), .led5_n(led5_n), .spi_miso(spi_miso),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .rd_ready(rd_ready)
);

// File: tb/spi_glue_cmd_decoder_bench.sv
`timescale 1ns/1ps
module spi_glue_cmd_decoder_bench;
  localparam int H = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, spi_mosi2 = 1'b0;
  logic spi_miso, wr_valid, rd_ready, nand_ce_n, led5_n;
  logic wr_ready = 1'b0, rd_valid = 1'b0;
  logic [7:0] wr_data, rd_data = 8'h00;
  logic [3:0] led_n;
  logic [2:0] spare_out;

  int checks = 0, fails = 0;
  logic [7:0] rd_mem [0:7];
  int rd_n = 0, rd_idx = 0;
  bit rd_adv = 0;
  logic [7:0] wr_got [0:15];
  int wr_cnt = 0;

  always #2.5 clk = ~clk;

  spi_glue_cmd_decoder u_spi_glue_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_mosi2(spi_mosi2), .spi_miso(spi_miso),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .led_n(led_n), .nand_ce_n(nand_ce_n), .spare_out(spare_out), .led5_n(led5_n)
  );

  // read-side source: handshake decided at the negedge before the posedge
  always @(negedge clk) begin
    #1;
    if (rd_adv) begin rd_idx = rd_idx + 1; rd_adv = 0; end
    rd_valid = (rd_idx < rd_n);
    rd_data  = rd_valid ? rd_mem[rd_idx] : 8'h00;
    if (rd_valid && rd_ready) rd_adv = 1;
  end

  // write-side sink recorder
  always @(negedge clk) begin
    #1;
    if (wr_valid && wr_ready && wr_cnt < 16) begin
      wr_got[wr_cnt] = wr_data;
      wr_cnt = wr_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input bit dual, output logic [7:0] rx);
    rx = 8'h00;
    if (!dual) begin
      for (int i = 7; i >= 0; i--) begin
        spi_mosi = tx[i];
        repeat (H) @(negedge clk);
        rx[i] = spi_miso;
        spi_sclk = 1'b1;
        repeat (H) @(negedge clk);
        spi_sclk = 1'b0;
      end
    end else begin
      for (int i = 3; i >= 0; i--) begin
        spi_mosi  = tx[2*i+1];
        spi_mosi2 = tx[2*i];
        repeat (H) @(negedge clk);
        spi_sclk = 1'b1;
        repeat (H) @(negedge clk);
        spi_sclk = 1'b0;
      end
    end
  endtask

  task automatic partial(input logic [7:0] tx, input int k);
    for (int i = 7; i > 7 - k; i--) begin
      spi_mosi = tx[i];
      repeat (H) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (H) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic fbegin();
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic fend();
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cmd2(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    fbegin(); xfer(a, 0, r); xfer(b, 0, r); fend();
  endtask

  task automatic t_reset();
    chk("R1 led_n", led_n, 4'hF);
    chk("R1 nand_ce_n", nand_ce_n, 1);
    chk("R1 spare_out", spare_out, 0);
    chk("R1 led5_n", led5_n, 1);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 rd_ready", rd_ready, 0);
    chk("R11 miso idle", spi_miso, 0);
  endtask

  task automatic t_cfg();
    logic [7:0] r;
    cmd2(8'h09, 8'hA6);
    chk("R2 led_n", led_n, 4'h6);
    chk("R2 nand_ce_n", nand_ce_n, 0);
    chk("R2 spare_out", spare_out, 3'h5);
    fbegin(); xfer(8'h09, 0, r); xfer(8'h3C, 0, r); xfer(8'h55, 0, r); fend();
    chk("R2 cfg extra byte ignored", {spare_out, nand_ce_n, led_n}, 8'h3C);
  endtask

  task automatic t_led5();
    logic [7:0] r;
    fbegin(); xfer(8'h0C, 0, r);
    repeat (4) @(negedge clk);
    chk("R3 led5 on before frame end", led5_n, 0);
    xfer(8'h09, 0, r); xfer(8'h00, 0, r); fend();
    chk("R3 bytes after led cmd ignored", {spare_out, nand_ce_n, led_n}, 8'h3C);
    fbegin(); xfer(8'h0D, 0, r); fend();
    chk("R3 led5 off", led5_n, 1);
  endtask

  task automatic t_unknown();
    logic [7:0] r;
    fbegin(); xfer(8'h5A, 0, r); xfer(8'h09, 0, r); xfer(8'h00, 0, r); xfer(8'h0C, 0, r); fend();
    chk("R10 cfg unchanged", {spare_out, nand_ce_n, led_n}, 8'h3C);
    chk("R10 led5 unchanged", led5_n, 1);
    chk("R10 no write output", wr_valid, 0);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    fbegin(); xfer(8'h09, 0, r); partial(8'h00, 4); fend();
    chk("R9 aborted cfg byte discarded", {spare_out, nand_ce_n, led_n}, 8'h3C);
    fbegin(); partial(8'h0C, 5); fend();
    chk("R9 aborted opcode no effect", led5_n, 1);
    fbegin(); xfer(8'h0C, 0, r); fend();
    chk("R9 next frame decodes opcode", led5_n, 0);
    fbegin(); xfer(8'h0D, 0, r); fend();
  endtask

  task automatic t_write();
    logic [7:0] r;
    wr_cnt = 0; wr_ready = 1'b1;
    fbegin(); xfer(8'h08, 0, r);
    xfer(8'h12, 1, r); xfer(8'hB7, 1, r); xfer(8'h4E, 1, r); xfer(8'h00, 1, r);
    fend();
    chk("R4 byte count (trailer dropped)", wr_cnt, 3);
    chk("R4 byte0", wr_got[0], 8'h12);
    chk("R4 byte1", wr_got[1], 8'hB7);
    chk("R4 byte2", wr_got[2], 8'h4E);
    chk("R4 no trailer pending", wr_valid, 0);
    wr_ready = 1'b0;
  endtask

  task automatic t_write_bp();
    logic [7:0] r;
    wr_cnt = 0; wr_ready = 1'b0;
    fork
      begin
        fbegin(); xfer(8'h08, 0, r);
        xfer(8'hC3, 1, r); xfer(8'h5A, 1, r); xfer(8'h96, 1, r); xfer(8'h00, 1, r);
        fend();
      end
      begin
        do @(negedge clk); while (!wr_valid);
        repeat (23) @(negedge clk);
        chk("R5 valid held", wr_valid, 1);
        chk("R5 data held", wr_data, 8'hC3);
        wr_ready = 1'b1;
      end
    join
    chk("R5 count across collision", wr_cnt, 3);
    chk("R5 byte0", wr_got[0], 8'hC3);
    chk("R5 byte1", wr_got[1], 8'h5A);
    chk("R5 byte2", wr_got[2], 8'h96);
    wr_ready = 1'b0;
  endtask

  task automatic t_read(input logic [7:0] op, input int dummies, input string tag);
    logic [7:0] r;
    fbegin(); xfer(op, 0, r);
    chk({tag, " R11 miso low in opcode"}, r, 8'h00);
    for (int i = 0; i < dummies; i++) begin
      xfer(8'h00, 0, r);
      chk({tag, " R11 miso low in dummy"}, r, 8'h00);
    end
    xfer(8'h00, 0, r); chk({tag, " data0"}, r, rd_mem[0]);
    xfer(8'h00, 0, r); chk({tag, " data1"}, r, rd_mem[1]);
    xfer(8'h00, 0, r); chk({tag, " R8 empty slot gives FF"}, r, 8'hFF);
    fend();
    chk({tag, " R8 rd_ready low after frame"}, rd_ready, 0);
    chk({tag, " R11 miso low after frame"}, spi_miso, 0);
  endtask

  bit finished = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_cfg();
    t_led5();
    t_unknown();
    t_abort();
    t_write();
    t_write_bp();
    rd_mem[0] = 8'hA5; rd_mem[1] = 8'h3C; rd_idx = 0; rd_n = 2;
    t_read(8'h0A, 1, "R6");
    rd_mem[0] = 8'h81; rd_mem[1] = 8'h7E; rd_idx = 0; rd_n = 2;
    t_read(8'h0B, 4, "R7");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule